// File: doc/BRIEF.md
# E1 Timeslot-Zero Transmit Inserter

This block produces the contents of timeslot zero of an outgoing E1 frame as a serial bit stream. A bit clock advances it one bit period per cycle. A single-cycle frame start strobe, `frs`, marks bit 1 of timeslot zero. Frames alternate between two types. An alignment frame carries the fixed alignment pattern in bits 2 to 8. A service frame carries a 1 in bit 2 and six national bits in bits 3 to 8. Both types carry the international bit in bit 1. Outside timeslot zero the serial output is held low, so the outer framer can OR the payload timeslots onto it.

Every input is captured on the clock edge that starts a frame, and a frame runs for 256 bit periods. A strobe that arrives early restarts the frame at once. If no strobe arrives, the block starts the next frame by itself after 256 bits. A marker output flags alignment frames. It rises and falls at bit 2 of timeslot 1 instead of at a timeslot boundary.

The block moves bits on a fixed time-division grid, and the line cannot pause. For that reason there is no valid/ready handshake and no back-pressure. The upstream logic must present the national and international bits before each frame start. Every pin is a plain control or data pin.

Top module: `e1_ts0_inserter`

## Requirements
- R1: Until the first frame start after reset, `ser_out` and `sync_mark` are both low, whatever the other inputs do.
- R2: From bit position 8 to bit position 255 of a frame (counting bit 1 of timeslot zero as position 0), `ser_out` is low.
- R3: `intl_bit`, sampled on the frame-start edge, appears on `ser_out` in the cycle that follows that edge (position 0), in both frame types.
- R4: In an alignment frame, positions 1 to 7 carry 0,0,1,1,0,1,1 in that order.
- R5: In a service frame, position 1 carries 1, and `nat_bits[k]` carries position k+2 for k = 0 to 5 (so `nat_bits[5]` carries bit 8).
- R6: `sync_mark` is high from position 0 to position 8 of an alignment frame and from position 9 to the end of a service frame. Otherwise it is low. It changes only on the edge that enters position 9, or on a frame start.
- R7: Frame types strictly alternate. The first frame after reset is an alignment frame.
- R8: `nat_bits` and `intl_bit` are sampled only on the frame-start edge. Changes at any other time do not affect the frame.
- R9: `frs` at any position restarts the frame at position 0 on the next edge. That frame is a new frame of the alternate type.
- R10: When no strobe arrives, the block begins a new frame after position 255. It captures the inputs on that edge and alternates the frame type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frs | input | 1 | Frame start strobe, one cycle, marks bit 1 of timeslot zero |
| nat_bits | input | 6 | National bits for service frames; bit k goes to timeslot bit k+3 |
| intl_bit | input | 1 | International bit, sent in bit 1 of every frame |
| ser_out | output | 1 | Serial timeslot-zero stream, low outside timeslot zero |
| sync_mark | output | 1 | Alignment frame marker, switching at bit 2 of timeslot 1 |

## Verification
Both outputs are registered, so each result is due on the clock edge that follows its cause. The bit at position 0 is visible after the frame-start edge. The bit at position p is visible p edges after that, and the marker changes on the edge that enters position 9. The bench drives and samples on the falling edge. A cycle model in the bench advances on each falling-edge step and mirrors the edge that will follow. The sample taken at each falling edge is compared with the model's position for the edge just passed. Randomised frame lengths, back-to-back strobes and frames with no strobe move that position to the points where restart and self-start take effect.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int SLOT_BITS = 8;
  localparam int NAT_W     = SLOT_BITS - 2;
  // slot bits 8..2 of the alignment pattern, written w[7:1]
  localparam logic [SLOT_BITS-2:0] ALIGN_TAIL = 7'b1101100;

  // word indexed by transmit position: w[0] leaves first
  function automatic logic [SLOT_BITS-1:0] ts0_word(input logic is_sync,
                                                   input logic [NAT_W-1:0] nat,
                                                   input logic intl);
    return is_sync ? {ALIGN_TAIL, intl} : {nat, 1'b1, intl};
  endfunction
endpackage

// File: rtl/e1_ts0_timebase.sv
module e1_ts0_timebase #(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frs,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             started_q,
  output logic             sync_q,
  output logic             sync_next,
  output logic             frame_start
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  assign frame_start = frs | (started_q & (cnt_q == LAST));
  assign sync_next   = started_q ? ~sync_q : 1'b1;

  always_comb begin
    if (frame_start)    cnt_next = '0;
    else if (started_q) cnt_next = cnt_q + 1'b1;
    else                cnt_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      sync_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      if (frame_start) begin
        started_q <= 1'b1;
        sync_q    <= sync_next;
      end
    end
  end
endmodule

// File: rtl/e1_ts0_word.sv
module e1_ts0_word
  import e1_ts0_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 sync_next,
  input  logic [NAT_W-1:0]     nat,
  input  logic                 intl,
  output logic [SLOT_BITS-1:0] word_now,
  output logic [SLOT_BITS-1:0] word_q
);
  assign word_now = ts0_word(sync_next, nat, intl);

  always_ff @(posedge clk) begin
    if (!rst_n)           word_q <= '0;
    else if (frame_start) word_q <= word_now;
  end
endmodule

// File: rtl/e1_ts0_serializer.sv
module e1_ts0_serializer
  import e1_ts0_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic [CNT_W-1:0]     cnt_next,
  input  logic [SLOT_BITS-1:0] word_now,
  input  logic [SLOT_BITS-1:0] word_q,
  output logic                 ser_out
);
  localparam int               IDX_W  = $clog2(SLOT_BITS);
  localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(SLOT_BITS);

  logic bit_next;

  always_comb begin
    if (frame_start)          bit_next = word_now[0];
    else if (cnt_next < SLOT_C) bit_next = word_q[cnt_next[IDX_W-1:0]];
    else                      bit_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ser_out <= 1'b0;
    else        ser_out <= bit_next;
  end
endmodule

// File: rtl/e1_ts0_marker.sv
module e1_ts0_marker #(
  parameter int CNT_W    = 8,
  parameter int MARK_POS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             sync_q,
  input  logic             sync_next,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             sync_mark
);
  localparam logic [CNT_W-1:0] MARK_C = CNT_W'(MARK_POS);

  always_ff @(posedge clk) begin
    if (!rst_n)                 sync_mark <= 1'b0;
    else if (frame_start)       sync_mark <= sync_next;
    else if (cnt_next == MARK_C) sync_mark <= ~sync_q;
  end
endmodule

// File: rtl/e1_ts0_inserter.sv
module e1_ts0_inserter
  import e1_ts0_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int MARK_POS   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frs,
  input  logic [NAT_W-1:0] nat_bits,
  input  logic             intl_bit,
  output logic             ser_out,
  output logic             sync_mark
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0]     cnt_q, cnt_next;
  logic                 started_q, sync_q, sync_next, frame_start;
  logic [SLOT_BITS-1:0] word_now, word_q;

  e1_ts0_timebase #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .frs(frs),
    .cnt_q(cnt_q), .cnt_next(cnt_next), .started_q(started_q),
    .sync_q(sync_q), .sync_next(sync_next), .frame_start(frame_start)
  );

  e1_ts0_word u_word (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sync_next(sync_next),
    .nat(nat_bits), .intl(intl_bit), .word_now(word_now), .word_q(word_q)
  );

  e1_ts0_serializer #(.CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cnt_next(cnt_next),
    .word_now(word_now), .word_q(word_q), .ser_out(ser_out)
  );

  e1_ts0_marker #(.CNT_W(CNT_W), .MARK_POS(MARK_POS)) u_mark (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sync_q(sync_q),
    .sync_next(sync_next), .cnt_next(cnt_next), .sync_mark(sync_mark)
  );
endmodule

// File: rtl/e1_ts0_checker.sv
module e1_ts0_checker #(
  parameter int CNT_W    = 8,
  parameter int MARK_POS = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frs,
  input logic             intl_bit,
  input logic             ser_out,
  input logic             sync_mark,
  input logic [CNT_W-1:0] cnt_q,
  input logic             started_q,
  input logic             sync_q,
  input logic             frame_start
);
  localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(8);
  localparam logic [CNT_W-1:0] MARK_C = CNT_W'(MARK_POS);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  a_r2_low_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!started_q || cnt_q >= SLOT_C) |-> !ser_out);

  a_r3_intl_first: assert property (@(posedge clk) disable iff (!rst_n)
    frs |=> (ser_out == $past(intl_bit)));

  a_r4_align_bit2_low: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && sync_q && cnt_q == ONE_C) |-> !ser_out);

  a_r6_mark_switch_points: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_mark) |-> (cnt_q == MARK_C || cnt_q == '0));

  a_r7_type_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && started_q) |=> (sync_q != $past(sync_q)));

  a_r9_strobe_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    frs |=> (cnt_q == '0 && started_q));
endmodule

bind e1_ts0_inserter e1_ts0_checker #(.CNT_W(CNT_W), .MARK_POS(MARK_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frs(frs), .intl_bit(intl_bit), .ser_out(ser_out),
  .sync_mark(sync_mark), .cnt_q(cnt_q), .started_q(started_q), .sync_q(sync_q),
  .frame_start(frame_start)
);

// File: tb/e1_ts0_inserter_tb.sv
module e1_ts0_inserter_tb;
  localparam int FB   = 256;
  localparam int MARK = 9;

  logic       clk = 1'b0;
  logic       rst_n, frs, intl_bit;
  logic [5:0] nat_bits;
  logic       ser_out, sync_mark;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the state after the coming edge
  bit       m_started = 0, m_sync = 0, m_wrap = 0, m_realign = 0;
  bit [5:0] m_nat = '0;
  bit       m_intl = 0;
  int       m_pos = 0;

  always #10 clk = ~clk;

  e1_ts0_inserter #(.FRAME_BITS(FB), .MARK_POS(MARK)) u_dut (
    .clk(clk), .rst_n(rst_n), .frs(frs), .nat_bits(nat_bits),
    .intl_bit(intl_bit), .ser_out(ser_out), .sync_mark(sync_mark)
  );

  function automatic bit exp_ser(int pos, bit s, bit [5:0] nat, bit intl);
    bit [7:0] w;
    w = s ? {7'b1101100, intl} : {nat, 1'b1, intl};
    return (pos < 8) ? w[pos] : 1'b0;
  endfunction

  function automatic bit exp_mark(int pos, bit s);
    return (pos < MARK) ? s : !s;
  endfunction

  function automatic string ser_tag(int pos, bit s, bit wrap, bit realign);
    if (pos >= 8)  return "R2";
    if (pos == 0)  return wrap ? "R10" : (realign ? "R9" : "R3");
    if (s)         return "R4";
    if (pos == 1)  return "R7";
    return "R5 R8";
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pos=%0d actual=%0b expected=%0b", req, m_pos, act, exp);
    end
  endtask

  // at a falling edge: check, drive, advance model, wait one cycle
  task automatic step(bit f);
    bit fs;
    if (!m_started) begin
      check("R1", ser_out, 1'b0);
      check("R1", sync_mark, 1'b0);
    end else begin
      check(ser_tag(m_pos, m_sync, m_wrap, m_realign), ser_out,
            exp_ser(m_pos, m_sync, m_nat, m_intl));
      check("R6", sync_mark, exp_mark(m_pos, m_sync));
    end
    frs      = f;
    nat_bits = 6'($urandom);
    intl_bit = 1'($urandom);
    fs = f || (m_started && m_pos == FB - 1);
    if (fs) begin
      m_realign = f && m_started && (m_pos != FB - 1);
      m_wrap    = !f;
      m_sync    = m_started ? !m_sync : 1'b1;
      m_started = 1'b1;
      m_nat     = nat_bits;
      m_intl    = intl_bit;
      m_pos     = 0;
    end else if (m_started) begin
      m_pos++;
    end
    @(negedge clk);
  endtask

  task automatic run_frame(int len);
    step(1'b1);
    for (int i = 1; i < len; i++) step(1'b0);
  endtask

  initial begin
    void'($urandom(32'h51E1_0B07));
    rst_n = 1'b0; frs = 1'b0; nat_bits = '0; intl_bit = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", ser_out, 1'b0);
    check("R1", sync_mark, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) step(1'b0);          // idle, R1
    for (int i = 0; i < 3; i++) run_frame(FB);        // steady frames, R7
    run_frame(MARK);                                  // restart at marker point, R9
    run_frame(1);                                     // back-to-back strobes, R9
    run_frame(2);
    run_frame(FB + 40);                               // self-started frame, R10
    run_frame(FB);
    for (int f = 0; f < 50; f++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0)      run_frame(1 + int'($urandom % (FB - 1)));
      else if (r == 1) run_frame(FB + 1 + int'($urandom % FB));
      else             run_frame(FB);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule